// File: doc/BRIEF.md
# Synchronous Host Bus Target

This block is the target end of a synchronous host processor bus that uses a chip select. A host selects the block, gives a direction and an address, and then waits for the block's active-low transfer acknowledge. Reads and writes are paced by the readiness of an internal register bank. That bank is reached through a request/valid port whose read latency can vary. The acknowledge and the read data are presented as separate value and output-enable signals, so the pad ring builds the tri-state buffers. The acknowledge enable follows chip select on falling clock edges. The acknowledge level only changes on rising edges.

The block also holds two interrupt lines. Each line has a sticky status register that is set by event pulses and cleared by writing ones, and a mask register. Both sit in a small local window of the address space and are answered with no wait. The block drives two active-low DMA request outputs. One asks the host to write into the block while the block has space. The other asks the host to read from the block while data is pending. Each request drops while the host grants that channel.

Handshake states: `ST_IDLE` waits for selection. When chip select is sampled low it goes to `ST_RD_ISSUE` (external read), `ST_RD_ACK` (local read), `ST_WR_WAIT` (external write) or `ST_WR_ACK` (local write). `ST_RD_ISSUE` moves to `ST_RD_ACK` when read-valid is high and otherwise to `ST_RD_WAIT`. `ST_RD_WAIT` holds until read-valid, then moves to `ST_RD_ACK`. `ST_WR_WAIT` holds until write-ready, then moves to `ST_WR_ACK`. Both acknowledge states move to `ST_DONE` after one cycle. `ST_DONE` returns to `ST_IDLE` once chip select is sampled high.

Top module: `hostbus_target`

## Requirements
- R1: During and right after reset: acknowledge enable and data enable are 0, the acknowledge level is 1, both DMA requests and both interrupt outputs are 1, and the read and write strobes are 0.
- R2: The acknowledge enable becomes 1 on the falling clock edge after chip select is sampled low. Until the access is ready, the driven acknowledge level is 1.
- R3: For an external read (address bit AW-1 = 0), the block pulses the read strobe once. The acknowledge goes low on the rising edge after read-valid is sampled high, so the host sees L+1 high cycles for a read-valid that comes L cycles after the strobe. While the acknowledge is low, the data enable is 1 and the data output carries the returned word.
- R4: For an external write, the acknowledge goes low on the rising edge after write-ready is sampled high. With ready raised W cycles into the access, the host sees max(W,1) high cycles.
- R5: Write data is captured on the rising edge that ends the acknowledge cycle. One cycle later the block pulses the write strobe for one cycle with the word address (address bits AW-2..0) and that data.
- R6: The acknowledge enable returns to 0 on the falling edge after chip select is sampled high. The data enable is 1 only in the read acknowledge cycle.
- R7: DMA request 0 is low one cycle after space-available is high while grant 0 is high. It goes high the cycle after grant 0 is low, and returns low after grant 0 is released if space is still available.
- R8: DMA request 1 behaves the same way, using data-pending and grant 1.
- R9: An event pulse on source bit i of line k sets status bit i of line k. Two cycles later the interrupt output k is low if any status bit of that line is set and unmasked (mask bit 1 = enabled). Masked bits leave the output high.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. When a bit has an event in the same cycle as its clear, the event wins.
- R11: The local window is address bit AW-1 = 1. Bit 1 selects the line and bit 0 selects status (0) or mask (1). Local reads return the value zero-extended. Local reads and writes acknowledge on the first rising edge after selection, with zero high cycles.
- R12: Local accesses never pulse the read or write strobe of the register-bank port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_cs_n | input | 1 | Chip select, active low |
| hb_rd | input | 1 | Direction: 1 read, 0 write |
| hb_addr | input | AW | Access address |
| hb_data_i | input | DW | Write data from host |
| hb_data_o | output | DW | Read data toward host |
| hb_data_oe | output | 1 | Read data output enable |
| hb_ack_n_o | output | 1 | Acknowledge level, active low |
| hb_ack_oe | output | 1 | Acknowledge output enable |
| dma_gnt_n | input | 2 | Host DMA grant per channel, active low |
| dma_req_n | output | 2 | DMA request per channel, active low |
| irq_n | output | 2 | Interrupt request per line, active low |
| dma_space | input | 1 | Block can take DMA write data |
| dma_pending | input | 1 | Block holds data for DMA read |
| irq_evt | input | 2*NSRC | Event pulses, line k at bits k*NSRC+i |
| reg_rd | output | 1 | Register-bank read strobe |
| reg_wen | output | 1 | Register-bank write strobe |
| reg_addr | output | AW-1 | Register-bank word address |
| reg_wdata | output | DW | Register-bank write data |
| reg_rdata | input | DW | Register-bank read data |
| reg_rvalid | input | 1 | Register-bank read data valid |
| reg_wready | input | 1 | Register bank can accept a write |

## Verification
The bench counts the high acknowledge cycles the host sees after selection. For external reads the expected count is one more than the modelled latency. For external writes it is the ready delay, and for local accesses it is zero. Write strobes are due one cycle after the capture edge. Interrupt changes are due two cycles after an event, and DMA request changes one cycle after a grant or condition change. All outputs are sampled 3 ns after a rising edge, so each result is read in the cycle worked out from its registers. Expected read words and write strobes sit in scoreboard queues that a monitor drains as the strobes and acknowledge cycles appear.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
    localparam int HBT_NLINES = 2;
    localparam int HBT_NDMA   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_RD_ACK,
        ST_WR_WAIT,
        ST_WR_ACK,
        ST_DONE
    } hbt_state_e;
endpackage

// File: rtl/hbt_fsm.sv
module hbt_fsm
    import hbt_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] local_rdata,
    input  logic [DW-1:0] bank_rdata,
    input  logic          bank_rvalid,
    input  logic          bank_wready,
    output logic          ack_n,
    output logic          ack_oe,
    output logic [DW-1:0] data_o,
    output logic          data_oe,
    output logic          bank_rd,
    output logic          bank_wen,
    output logic          local_we,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q
);
    hbt_state_e state_q, state_d;
    logic       is_local;
    logic [DW-1:0] rdata_q;

    assign is_local = addr[AW-1];

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n) begin
                    if (rd) state_d = is_local ? ST_RD_ACK : ST_RD_ISSUE;
                    else    state_d = is_local ? ST_WR_ACK : ST_WR_WAIT;
                end
            end
            ST_RD_ISSUE: state_d = bank_rvalid ? ST_RD_ACK : ST_RD_WAIT;
            ST_RD_WAIT:  state_d = bank_rvalid ? ST_RD_ACK : ST_RD_WAIT;
            ST_RD_ACK:   state_d = ST_DONE;
            ST_WR_WAIT:  state_d = bank_wready ? ST_WR_ACK : ST_WR_WAIT;
            ST_WR_ACK:   state_d = ST_DONE;
            ST_DONE:     state_d = cs_n ? ST_IDLE : ST_DONE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // state-decoded outputs
    always_comb begin
        ack_n   = 1'b1;
        data_oe = 1'b0;
        bank_rd = 1'b0;
        unique case (state_q)
            ST_RD_ISSUE: bank_rd = 1'b1;
            ST_RD_ACK: begin
                ack_n   = 1'b0;
                data_oe = 1'b1;
            end
            ST_WR_ACK:   ack_n = 1'b0;
            default: ;
        endcase
    end

    assign data_o = rdata_q;

    // acknowledge enable follows chip select on falling edges
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) ack_oe <= 1'b0;
        else        ack_oe <= !cs_n;
    end

    // address, read data and write capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            rdata_q  <= '0;
            wdata_q  <= '0;
            bank_wen <= 1'b0;
            local_we <= 1'b0;
        end else begin
            bank_wen <= 1'b0;
            local_we <= 1'b0;
            if (state_q == ST_IDLE && !cs_n) begin
                addr_q <= addr;
                if (rd && is_local) rdata_q <= local_rdata;
            end
            if ((state_q == ST_RD_ISSUE || state_q == ST_RD_WAIT) && bank_rvalid)
                rdata_q <= bank_rdata;
            if (state_q == ST_WR_ACK) begin
                wdata_q  <= data_i;
                bank_wen <= !addr_q[AW-1];
                local_we <= addr_q[AW-1];
            end
        end
    end
endmodule

// File: rtl/hbt_irq_line.sv
module hbt_irq_line #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            wr_status,
    input  logic            wr_mask,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] mask,
    output logic            irq_n
);
    logic [NSRC-1:0] clr;

    assign clr = wr_status ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
            irq_n  <= 1'b1;
        end else begin
            status <= (status & ~clr) | evt;
            if (wr_mask) mask <= wdata;
            irq_n  <= ~|(status & mask);
        end
    end
endmodule

// File: rtl/hbt_dma_chan.sv
module hbt_dma_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic gnt_n,
    output logic req_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_n <= 1'b1;
        else        req_n <= ~(cond & gnt_n);
    end
endmodule

// File: rtl/hostbus_target.sv
module hostbus_target
    import hbt_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 16,
    parameter int NSRC = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hb_cs_n,
    input  logic                       hb_rd,
    input  logic [AW-1:0]              hb_addr,
    input  logic [DW-1:0]              hb_data_i,
    output logic [DW-1:0]              hb_data_o,
    output logic                       hb_data_oe,
    output logic                       hb_ack_n_o,
    output logic                       hb_ack_oe,
    input  logic [HBT_NDMA-1:0]        dma_gnt_n,
    output logic [HBT_NDMA-1:0]        dma_req_n,
    output logic [HBT_NLINES-1:0]      irq_n,
    input  logic                       dma_space,
    input  logic                       dma_pending,
    input  logic [HBT_NLINES*NSRC-1:0] irq_evt,
    output logic                       reg_rd,
    output logic                       reg_wen,
    output logic [AW-2:0]              reg_addr,
    output logic [DW-1:0]              reg_wdata,
    input  logic [DW-1:0]              reg_rdata,
    input  logic                       reg_rvalid,
    input  logic                       reg_wready
);
    localparam int PADW = DW - NSRC;

    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic [DW-1:0]   local_rdata;
    logic            local_we;
    logic [NSRC-1:0] st_v [HBT_NLINES];
    logic [NSRC-1:0] mk_v [HBT_NLINES];
    logic [HBT_NDMA-1:0] dma_cond;

    hbt_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (hb_cs_n),
        .rd          (hb_rd),
        .addr        (hb_addr),
        .data_i      (hb_data_i),
        .local_rdata (local_rdata),
        .bank_rdata  (reg_rdata),
        .bank_rvalid (reg_rvalid),
        .bank_wready (reg_wready),
        .ack_n       (hb_ack_n_o),
        .ack_oe      (hb_ack_oe),
        .data_o      (hb_data_o),
        .data_oe     (hb_data_oe),
        .bank_rd     (reg_rd),
        .bank_wen    (reg_wen),
        .local_we    (local_we),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q)
    );

    assign reg_addr  = addr_q[AW-2:0];
    assign reg_wdata = wdata_q;

    // local window read mux on the live address: bit1 line, bit0 status/mask
    always_comb begin
        if (hb_addr[0]) local_rdata = {{PADW{1'b0}}, mk_v[hb_addr[1]]};
        else            local_rdata = {{PADW{1'b0}}, st_v[hb_addr[1]]};
    end

    generate
        for (genvar g = 0; g < HBT_NLINES; g++) begin : g_line
            logic sel;
            assign sel = local_we && (addr_q[1] == g[0]);
            hbt_irq_line #(.NSRC(NSRC)) u_line (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt       (irq_evt[g*NSRC +: NSRC]),
                .wr_status (sel && !addr_q[0]),
                .wr_mask   (sel && addr_q[0]),
                .wdata     (wdata_q[NSRC-1:0]),
                .status    (st_v[g]),
                .mask      (mk_v[g]),
                .irq_n     (irq_n[g])
            );
        end
    endgenerate

    assign dma_cond = {dma_pending, dma_space};

    generate
        for (genvar c = 0; c < HBT_NDMA; c++) begin : g_dma
            hbt_dma_chan u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .cond  (dma_cond[c]),
                .gnt_n (dma_gnt_n[c]),
                .req_n (dma_req_n[c])
            );
        end
    endgenerate
endmodule

// File: rtl/hbt_checker.sv
module hbt_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hb_cs_n,
    input logic          hb_rd,
    input logic [AW-1:0] hb_addr,
    input logic          hb_ack_n_o,
    input logic          hb_ack_oe,
    input logic          hb_data_oe,
    input logic [1:0]    dma_gnt_n,
    input logic [1:0]    dma_req_n,
    input logic          reg_rd,
    input logic          reg_wen,
    input logic          reg_wready
);
    // R2
    ack_en_tracks_cs_chk: assert property (@(negedge clk) disable iff (!rst_n)
        hb_ack_oe == !$past(hb_cs_n));

    // R3
    data_only_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hb_data_oe |-> !hb_ack_n_o);

    // R4
    wr_ack_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hb_ack_n_o) && !hb_rd && !hb_addr[AW-1]) |-> $past(reg_wready));

    // R5
    wen_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wen |-> $past(!hb_ack_n_o));

    // R3
    single_rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R7
    dma0_grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_gnt_n[0] |=> dma_req_n[0]);

    // R8
    dma1_grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_gnt_n[1] |=> dma_req_n[1]);
endmodule

bind hostbus_target hbt_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hb_cs_n    (hb_cs_n),
    .hb_rd      (hb_rd),
    .hb_addr    (hb_addr),
    .hb_ack_n_o (hb_ack_n_o),
    .hb_ack_oe  (hb_ack_oe),
    .hb_data_oe (hb_data_oe),
    .dma_gnt_n  (dma_gnt_n),
    .dma_req_n  (dma_req_n),
    .reg_rd     (reg_rd),
    .reg_wen    (reg_wen),
    .reg_wready (reg_wready)
);

// File: tb/hostbus_target_test.sv
module hostbus_target_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NSRC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hb_cs_n = 1'b1, hb_rd = 1'b0;
    logic [AW-1:0] hb_addr = '0;
    logic [DW-1:0] hb_data_i = '0;
    logic [DW-1:0] hb_data_o;
    logic hb_data_oe, hb_ack_n_o, hb_ack_oe;
    logic [1:0] dma_gnt_n = 2'b11;
    logic [1:0] dma_req_n, irq_n;
    logic dma_space = 1'b0, dma_pending = 1'b0;
    logic [2*NSRC-1:0] irq_evt = '0;
    logic reg_rd, reg_wen;
    logic [AW-2:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata = '0;
    logic reg_rvalid = 1'b0;
    logic reg_wready = 1'b1;

    int checks = 0;
    int fails = 0;
    int lat_cfg = 0;
    int rd_pulses = 0;
    bit finished = 0;

    logic [DW-1:0]      rd_q[$];
    logic [AW-1+DW-1:0] wr_q[$];

    always #5 clk = ~clk;

    hostbus_target #(.AW(AW), .DW(DW), .NSRC(NSRC)) uut (
        .clk(clk), .rst_n(rst_n), .hb_cs_n(hb_cs_n), .hb_rd(hb_rd),
        .hb_addr(hb_addr), .hb_data_i(hb_data_i), .hb_data_o(hb_data_o),
        .hb_data_oe(hb_data_oe), .hb_ack_n_o(hb_ack_n_o), .hb_ack_oe(hb_ack_oe),
        .dma_gnt_n(dma_gnt_n), .dma_req_n(dma_req_n), .irq_n(irq_n),
        .dma_space(dma_space), .dma_pending(dma_pending), .irq_evt(irq_evt),
        .reg_rd(reg_rd), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .reg_wready(reg_wready)
    );

    function automatic logic [DW-1:0] bank_word(input logic [AW-2:0] a);
        return (DW'(a) * 16'h0123) ^ 16'h5A5A;
    endfunction

    task automatic tick;
        @(posedge clk);
        #3;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // register bank model with programmable read latency
    initial begin
        int cnt;
        cnt = -1;
        forever begin
            tick;
            reg_rvalid = 1'b0;
            if (reg_rd) begin
                rd_pulses++;
                cnt = lat_cfg;
            end
            if (cnt == 0) begin
                reg_rvalid = 1'b1;
                reg_rdata  = bank_word(reg_addr);
                cnt = -1;
            end else if (cnt > 0) begin
                cnt--;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            tick;
            if (hb_data_oe && !hb_ack_n_o) begin
                if (rd_q.size() == 0) check(0, "R3 unexpected read data", int'(hb_data_o), 0);
                else begin
                    logic [DW-1:0] e;
                    e = rd_q.pop_front();
                    check(hb_data_o == e, "R3 read data", int'(hb_data_o), int'(e));
                end
            end
            if (reg_wen) begin
                if (wr_q.size() == 0) check(0, "R12 unexpected write strobe", int'(reg_addr), 0);
                else begin
                    logic [AW-1+DW-1:0] e;
                    e = wr_q.pop_front();
                    check({reg_addr, reg_wdata} == e, "R5 write strobe", int'({reg_addr, reg_wdata}), int'(e));
                end
            end
        end
    end

    task automatic host_access(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                               input int ready_delay, input int exp_waits, input string req);
        int waits;
        bit got;
        waits = 0;
        got = 0;
        hb_cs_n = 1'b0;
        hb_rd = rd;
        hb_addr = a;
        hb_data_i = wd;
        if (ready_delay > 0) begin
            reg_wready = 1'b0;
            fork
                begin
                    repeat (ready_delay) tick;
                    reg_wready = 1'b1;
                end
            join_none
        end
        for (int i = 0; i < 50; i++) begin
            tick;
            if (i == 0) check(hb_ack_oe == 1'b1, "R2 ack enable after select", int'(hb_ack_oe), 1);
            if (!hb_ack_n_o) begin
                got = 1;
                break;
            end
            waits++;
        end
        check(got && waits == exp_waits, req, waits, exp_waits);
        tick;
        hb_cs_n = 1'b1;
        hb_data_i = 16'hDEAD;
        tick;
        check(hb_ack_oe == 1'b0 && hb_data_oe == 1'b0, "R6 ack enable released",
              int'({hb_ack_oe, hb_data_oe}), 0);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        // R1 reset state
        check(hb_ack_oe == 0 && hb_data_oe == 0 && hb_ack_n_o == 1, "R1 bus outputs at reset",
              int'({hb_ack_oe, hb_data_oe, hb_ack_n_o}), 1);
        check(dma_req_n == 2'b11 && irq_n == 2'b11 && !reg_rd && !reg_wen, "R1 requests at reset",
              int'({dma_req_n, irq_n, reg_rd, reg_wen}), 8'h3C);
        rst_n = 1'b1;
        tick;
        check(dma_req_n == 2'b11 && irq_n == 2'b11 && hb_ack_oe == 0, "R1 after reset release",
              int'({dma_req_n, irq_n, hb_ack_oe}), 5'h1E);

        // R3 external reads, latency 0 and 3
        lat_cfg = 0;
        rd_q.push_back(bank_word(7'h12));
        host_access(1, 8'h12, '0, 0, 1, "R3 read waits latency 0");
        lat_cfg = 3;
        rd_q.push_back(bank_word(7'h35));
        host_access(1, 8'h35, '0, 0, 4, "R3 read waits latency 3");

        // R4 / R5 external writes
        wr_q.push_back({7'h07, 16'hBEEF});
        host_access(0, 8'h07, 16'hBEEF, 0, 1, "R4 write waits ready high");
        wr_q.push_back({7'h4C, 16'h1234});
        host_access(0, 8'h4C, 16'h1234, 4, 4, "R4 write waits ready after 4");

        // R7 DMA channel 0
        dma_space = 1'b1;
        tick;
        check(dma_req_n[0] == 0, "R7 request on space", int'(dma_req_n[0]), 0);
        dma_gnt_n[0] = 1'b0;
        tick;
        check(dma_req_n[0] == 1, "R7 drop on grant", int'(dma_req_n[0]), 1);
        dma_gnt_n[0] = 1'b1;
        tick;
        check(dma_req_n[0] == 0, "R7 reassert after grant", int'(dma_req_n[0]), 0);
        dma_space = 1'b0;
        tick;
        check(dma_req_n[0] == 1, "R7 idle without space", int'(dma_req_n[0]), 1);

        // R8 DMA channel 1
        dma_pending = 1'b1;
        tick;
        check(dma_req_n[1] == 0 && dma_req_n[0] == 1, "R8 request on pending", int'(dma_req_n), 1);
        dma_gnt_n[1] = 1'b0;
        tick;
        check(dma_req_n[1] == 1, "R8 drop on grant", int'(dma_req_n[1]), 1);
        dma_gnt_n[1] = 1'b1;
        tick;
        check(dma_req_n[1] == 0, "R8 reassert after grant", int'(dma_req_n[1]), 0);
        dma_pending = 1'b0;
        tick;

        // R11 local mask write (no wait), R12 no bank strobe
        host_access(0, 8'h81, 16'h000F, 0, 0, "R11 local write waits");

        // R9 event on enabled bit of line 0, masked bit of line 1
        irq_evt = 16'h2004;
        tick;
        irq_evt = '0;
        tick;
        check(irq_n == 2'b10, "R9 masked interrupt outputs", int'(irq_n), 2);

        // R11 local status read
        rd_q.push_back(16'h0004);
        host_access(1, 8'h80, '0, 0, 0, "R11 local read waits");
        rd_q.push_back(16'h0020);
        host_access(1, 8'h82, '0, 0, 0, "R11 line 1 status read waits");

        // R10 write-one-to-clear: writing 0 keeps, writing 1 clears
        host_access(0, 8'h80, 16'h0000, 0, 0, "R10 clear-zero write waits");
        tick;
        tick;
        check(irq_n[0] == 0, "R10 zero write keeps bit", int'(irq_n[0]), 0);
        host_access(0, 8'h80, 16'h0004, 0, 0, "R10 clear write waits");
        tick;
        tick;
        check(irq_n[0] == 1, "R10 interrupt released", int'(irq_n[0]), 1);
        rd_q.push_back(16'h0000);
        host_access(1, 8'h80, '0, 0, 0, "R10 status after clear waits");

        tick;
        check(rd_q.size() == 0 && wr_q.size() == 0, "R5 scoreboard drained",
              rd_q.size() + wr_q.size(), 0);
        check(rd_pulses == 2, "R12 read strobes only for external reads", rd_pulses, 2);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule